// File: doc/BRIEF.md
# Binary32 Normalise, Round and Pack Unit

This unit takes the unpacked intermediate result of a single-precision operation and turns it into a finished binary32 word. Each intermediate value has three parts: a sign, a signed biased exponent that may be negative, and a 32-bit significand. The significand keeps a guard field below the final LSB. The unit first normalises the significand. It then denormalises tiny values with a sticky right shift and applies one rounding increment chosen from the rounding mode. Finally it packs the result and reports inexact, overflow and underflow.

The exponent follows the unpacked convention: with the leading one at bit 30, the value is 1.f times 2^(exp-127). Packing adds the exponent, shifted to bit 23, to the significand shifted right by 8. The leading one therefore carries into the exponent field. Incoming exception bits are ORed into the outgoing flags. The arithmetic that produces the intermediate value sits outside this unit. One result is accepted per cycle, and outputs are registered.

Top module: `nrp_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid`, `out_word` and all three flags are zero.
- R2: `out_valid` is high exactly one cycle after `in_valid`. When `in_valid` is low, `out_word` and the flags hold their values.
- R3: If the exponent is 255 and either the significand is zero or `in_exc` is nonzero, rounding is skipped. The word is sign*2^31 + 255*2^23 + (sig >> 7), and the flags equal `in_exc`.
- R4: Any other input with a zero significand gives a signed zero, and the flags equal `in_exc`.
- R5: A nonzero significand is shifted left until bit 31 is set, and the exponent drops by the same amount. Exact inputs therefore pack correctly whatever their leading-zero count.
- R6: Mode 0 (nearest) adds 0x80 when bit 8 of the normalised significand is 1 and 0x7F when it is 0. Ties therefore go to even.
- R7: Mode 3 truncates. Mode 1 (toward +inf) adds 0xFF to positive values only. Mode 2 (toward -inf) adds 0xFF to negative values only.
- R8: If the increment carries out of 32 bits, the exponent rises by one. The significand then shifts right by one with bit 0 kept sticky, and the increment is halved.
- R9: `out_ixc` is set when any of the low 8 significand bits is nonzero before the increment is added.
- R10: If the exponent reaches 254 or more after rounding, both `out_ofc` and `out_ixc` are set. A zero increment gives the largest finite magnitude, 0x7F7FFFFF. Otherwise the result is infinity, 0x7F800000. The sign is kept in both cases.
- R11: A negative exponent triggers a sticky right shift by its magnitude and sets the exponent to 0. `out_ufc` is set only when the shifted value is inexact, the exponent is still 0, and the rounded significand is not above 0x80000000.
- R12: `in_exc` bits {underflow, overflow, inexact} = bits [2:0] are ORed into `out_ufc`, `out_ofc` and `out_ixc` on every path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Intermediate value present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Signed biased exponent |
| in_sig | input | 32 | Significand with guard field in bits [7:0] |
| in_mode | input | 2 | 0 nearest, 1 toward +inf, 2 toward -inf, 3 toward zero |
| in_exc | input | 3 | Incoming flags {underflow, overflow, inexact} |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_word | output | 32 | Packed binary32 result |
| out_ixc | output | 1 | Inexact |
| out_ofc | output | 1 | Overflow |
| out_ufc | output | 1 | Underflow |

## Verification
Every result and flag arrives exactly one clock edge after its input is accepted, because the path through the unit has a single register stage. The bench changes inputs on a falling edge and reads the outputs at the next falling edge. Each vector is therefore checked in the one cycle its result is valid, and the next vector is applied back to back in that same slot. The hold behaviour is checked by lowering `in_valid` and reading one edge later. The reset state is read one falling edge after reset is applied.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int SIG_W  = 32;
  localparam int GRD_W  = 7;
  localparam int EXP_W  = 10;
  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_UP      = 2'd1,
    RM_DOWN    = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;
endpackage

// File: rtl/nrp_norm.sv
// Normalise to bit SIG_W-1, then denormalise tiny values with a sticky shift.
module nrp_norm #(
  parameter int SIG_W = 32,
  parameter int EXP_W = 10,
  parameter int GRD_W = 7,
  localparam int EW   = EXP_W + 2,
  localparam int LZ_W = $clog2(SIG_W) + 1,
  localparam int SH_W = $clog2(2 * SIG_W)
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic signed [EW-1:0]    exp_o,
  output logic [SIG_W-1:0]        sig_o,
  output logic                    tiny_o
);
  logic [LZ_W-1:0]         lz;
  logic [SIG_W-1:0]        sig_n;
  logic signed [EW-1:0]    exp_n;
  logic signed [EW-1:0]    neg_e;
  logic [SH_W-1:0]         sh;
  logic [2*SIG_W-1:0]      wide;
  logic [SIG_W-1:0]        sig_d;

  // R5: leading-zero count, highest set bit wins
  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (sig_i[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  assign sig_n = sig_i << lz;
  assign exp_n = EW'(exp_i) - EW'($signed({1'b0, lz}));
  assign neg_e = -exp_n;

  // R11: sticky right shift, distances past the window collapse to a sticky 1
  always_comb begin
    if (neg_e > EW'(2 * SIG_W - 1)) sh = SH_W'(2 * SIG_W - 1);
    else                            sh = neg_e[SH_W-1:0];
    wide  = {sig_n, {SIG_W{1'b0}}} >> sh;
    sig_d = wide[2*SIG_W-1:SIG_W] | SIG_W'(|wide[SIG_W-1:0]);
  end

  always_comb begin
    if (exp_n < 0) begin
      exp_o  = '0;
      sig_o  = sig_d;
      tiny_o = |sig_d[GRD_W:0];
    end else begin
      exp_o  = exp_n;
      sig_o  = sig_n;
      tiny_o = 1'b0;
    end
  end
endmodule

// File: rtl/nrp_round.sv
// Mode-dependent increment with carry-out correction.
module nrp_round
  import nrp_pkg::*;
#(
  parameter int SIG_W = 32,
  parameter int GRD_W = 7,
  parameter int EW    = 12,
  localparam int LOWW = GRD_W + 1
) (
  input  logic                 sign_i,
  input  rmode_e               mode_i,
  input  logic signed [EW-1:0] exp_i,
  input  logic [SIG_W-1:0]     sig_i,
  output logic signed [EW-1:0] exp_o,
  output logic [SIG_W-1:0]     sig_o,
  output logic                 inexact_o,
  output logic                 incr_zero_o
);
  localparam logic [SIG_W-1:0] HALF = SIG_W'(1) << GRD_W;
  localparam logic [SIG_W-1:0] FULL = (SIG_W'(1) << LOWW) - SIG_W'(1);

  logic [SIG_W-1:0] incr, incr_c, sig_c;
  logic [SIG_W:0]   trial;

  // R6 / R7: increment selection
  always_comb begin
    unique case (mode_i)
      RM_NEAREST: incr = sig_i[LOWW] ? HALF : HALF - SIG_W'(1);
      RM_UP:      incr = sign_i ? '0 : FULL;
      RM_DOWN:    incr = sign_i ? FULL : '0;
      default:    incr = '0;
    endcase
  end

  assign trial = {1'b0, sig_i} + {1'b0, incr};

  // R8: carry out of the significand
  always_comb begin
    if (trial[SIG_W]) begin
      exp_o  = exp_i + EW'(1);
      sig_c  = (sig_i >> 1) | {{(SIG_W-1){1'b0}}, sig_i[0]};
      incr_c = incr >> 1;
    end else begin
      exp_o  = exp_i;
      sig_c  = sig_i;
      incr_c = incr;
    end
  end

  assign inexact_o   = |sig_c[LOWW-1:0];   // R9
  assign sig_o       = sig_c + incr_c;
  assign incr_zero_o = (incr_c == '0);
endmodule

// File: rtl/nrp_pack.sv
// Overflow saturation, underflow decision and additive field packing.
module nrp_pack #(
  parameter int SIG_W = 32,
  parameter int GRD_W = 7,
  parameter int EW    = 12,
  localparam int LOWW   = GRD_W + 1,
  localparam int MANT_W = SIG_W - GRD_W - 2,
  localparam int FLD_W  = SIG_W - 1 - MANT_W,
  localparam int OVF_E  = (1 << FLD_W) - 2
) (
  input  logic                 sign_i,
  input  logic signed [EW-1:0] exp_i,
  input  logic [SIG_W-1:0]     sig_i,
  input  logic                 tiny_i,
  input  logic                 inexact_i,
  input  logic                 incr_zero_i,
  output logic [SIG_W-1:0]     word_o,
  output logic                 ixc_o,
  output logic                 ofc_o,
  output logic                 ufc_o
);
  localparam logic [SIG_W-1:0] MSB_ONLY = SIG_W'(1) << (SIG_W - 1);

  logic [SIG_W-1:0] e_fld, s_fld;

  always_comb begin
    ufc_o = 1'b0;
    if (exp_i >= EW'(OVF_E)) begin
      // R10: saturate or go to infinity
      ofc_o = 1'b1;
      ixc_o = 1'b1;
      if (incr_zero_i) begin
        e_fld = SIG_W'(OVF_E - 1);
        s_fld = ~MSB_ONLY;
      end else begin
        e_fld = SIG_W'(OVF_E + 1);
        s_fld = '0;
      end
    end else begin
      ofc_o = 1'b0;
      ixc_o = inexact_i;
      e_fld = ((sig_i >> LOWW) == '0) ? '0 : SIG_W'(exp_i);
      // R11: underflow needs a tiny, inexact value that stayed below normal
      ufc_o = tiny_i && (e_fld == '0) && !(sig_i > MSB_ONLY);
      s_fld = sig_i >> 1;
    end
    word_o = MSB_ONLY * SIG_W'(sign_i) + (e_fld << MANT_W) + (s_fld >> GRD_W);
  end
endmodule

// File: rtl/nrp_unit.sv
module nrp_unit
  import nrp_pkg::*;
#(
  parameter int P_SIG_W = SIG_W,
  parameter int P_EXP_W = EXP_W,
  parameter int P_GRD_W = GRD_W,
  localparam int EW     = P_EXP_W + 2,
  localparam int MANT_W = P_SIG_W - P_GRD_W - 2,
  localparam int FLD_W  = P_SIG_W - 1 - MANT_W,
  localparam int INF_E  = (1 << FLD_W) - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      in_sign,
  input  logic signed [P_EXP_W-1:0] in_exp,
  input  logic [P_SIG_W-1:0]        in_sig,
  input  logic [1:0]                in_mode,
  input  logic [FLAG_W-1:0]         in_exc,
  output logic                      out_valid,
  output logic [P_SIG_W-1:0]        out_word,
  output logic                      out_ixc,
  output logic                      out_ofc,
  output logic                      out_ufc
);
  localparam logic [P_SIG_W-2:0] INF_BITS = {{FLD_W{1'b1}}, {MANT_W{1'b0}}};
  localparam logic [P_SIG_W-2:0] MAX_BITS = {{(FLD_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};

  logic signed [EW-1:0] n_exp, r_exp;
  logic [P_SIG_W-1:0]   n_sig, r_sig, p_word, byp_word, nxt_word;
  logic                 n_tiny, r_inx, r_iz, p_ixc, p_ofc, p_ufc;
  logic                 bypass, is_zero;
  logic [FLAG_W-1:0]    nxt_flags;

  nrp_norm #(.SIG_W(P_SIG_W), .EXP_W(P_EXP_W), .GRD_W(P_GRD_W)) u_norm (
    .exp_i(in_exp), .sig_i(in_sig), .exp_o(n_exp), .sig_o(n_sig), .tiny_o(n_tiny)
  );

  nrp_round #(.SIG_W(P_SIG_W), .GRD_W(P_GRD_W), .EW(EW)) u_round (
    .sign_i(in_sign), .mode_i(rmode_e'(in_mode)), .exp_i(n_exp), .sig_i(n_sig),
    .exp_o(r_exp), .sig_o(r_sig), .inexact_o(r_inx), .incr_zero_o(r_iz)
  );

  nrp_pack #(.SIG_W(P_SIG_W), .GRD_W(P_GRD_W), .EW(EW)) u_pack (
    .sign_i(in_sign), .exp_i(r_exp), .sig_i(r_sig), .tiny_i(n_tiny),
    .inexact_i(r_inx), .incr_zero_i(r_iz),
    .word_o(p_word), .ixc_o(p_ixc), .ofc_o(p_ofc), .ufc_o(p_ufc)
  );

  // R3 / R4: special inputs skip rounding
  assign bypass   = (in_exp == P_EXP_W'(INF_E)) && ((in_sig == '0) || (in_exc != '0));
  assign is_zero  = (in_sig == '0);
  assign byp_word = {in_sign, {(P_SIG_W-1){1'b0}}}
                  + (P_SIG_W'(in_exp[FLD_W-1:0]) << MANT_W)
                  + (in_sig >> P_GRD_W);

  always_comb begin
    if (bypass) begin
      nxt_word  = byp_word;
      nxt_flags = in_exc;
    end else if (is_zero) begin
      nxt_word  = {in_sign, {(P_SIG_W-1){1'b0}}};
      nxt_flags = in_exc;
    end else begin
      nxt_word  = p_word;
      nxt_flags = in_exc | {p_ufc, p_ofc, p_ixc};   // R12
    end
  end

  // R1 / R2: single output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ixc   <= 1'b0;
      out_ofc   <= 1'b0;
      out_ufc   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word                    <= nxt_word;
        {out_ufc, out_ofc, out_ixc} <= nxt_flags;
      end
    end
  end

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_word));

  a_r3_inf_bypass: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_exp == P_EXP_W'(INF_E) && in_sig == '0
    |=> out_word[P_SIG_W-2:0] == INF_BITS && out_word[P_SIG_W-1] == $past(in_sign));

  a_r4_zero_result: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sig == '0 && in_exp != P_EXP_W'(INF_E)
    |=> out_word[P_SIG_W-2:0] == '0 && {out_ufc, out_ofc, out_ixc} == $past(in_exc));

  a_r10_ovf_value: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ofc && $past(in_exc) == '0
    |-> out_word[P_SIG_W-2:0] == INF_BITS || out_word[P_SIG_W-2:0] == MAX_BITS);

  a_r10_ovf_inexact: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ofc && $past(in_exc) == '0 |-> out_ixc);

  a_r11_ufc_inexact: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ufc && $past(in_exc) == '0 |-> out_ixc);
endmodule

// File: tb/test_nrp_unit.sv
module test_nrp_unit;
  localparam int NV = 24;
  // {sign, exp[9:0], sig[31:0], mode[1:0], exc[2:0], word[31:0], flags{u,o,i}, req[3:0]}
  localparam logic [86:0] VEC [NV] = '{
    {1'b0, 10'd127,  32'h40000000, 2'd0, 3'b000, 32'h3F800000, 3'b000, 4'd5},  // R5 exact 1.0
    {1'b0, 10'd157,  32'h00000001, 2'd0, 3'b000, 32'h3F800000, 3'b000, 4'd5},  // R5 31 leading zeros
    {1'b0, 10'd126,  32'h80000080, 2'd0, 3'b000, 32'h3F800000, 3'b001, 4'd6},  // R6 tie to even, down
    {1'b0, 10'd126,  32'h80000180, 2'd0, 3'b000, 32'h3F800002, 3'b001, 4'd6},  // R6 tie to even, up
    {1'b0, 10'd126,  32'h800001FF, 2'd3, 3'b000, 32'h3F800001, 3'b001, 4'd7},  // R7 truncate
    {1'b0, 10'd126,  32'h80000101, 2'd1, 3'b000, 32'h3F800002, 3'b001, 4'd7},  // R7 +inf positive
    {1'b1, 10'd126,  32'h80000101, 2'd1, 3'b000, 32'hBF800001, 3'b001, 4'd7},  // R7 +inf negative
    {1'b1, 10'd126,  32'h80000101, 2'd2, 3'b000, 32'hBF800002, 3'b001, 4'd7},  // R7 -inf negative
    {1'b0, 10'd126,  32'h80000101, 2'd2, 3'b000, 32'h3F800001, 3'b001, 4'd7},  // R7 -inf positive
    {1'b0, 10'd126,  32'hFFFFFFC0, 2'd0, 3'b000, 32'h40000000, 3'b001, 4'd8},  // R8 carry to 2.0
    {1'b0, 10'd126,  32'h80000000, 2'd3, 3'b000, 32'h3F800000, 3'b000, 4'd9},  // R9 exact, no flag
    {1'b0, 10'd126,  32'h80000001, 2'd3, 3'b000, 32'h3F800000, 3'b001, 4'd9},  // R9 one sticky bit
    {1'b0, 10'd254,  32'h80000000, 2'd0, 3'b000, 32'h7F800000, 3'b011, 4'd10}, // R10 to infinity
    {1'b1, 10'd254,  32'h80000000, 2'd3, 3'b000, 32'hFF7FFFFF, 3'b011, 4'd10}, // R10 saturate
    {1'b0, 10'd253,  32'hFFFFFFC0, 2'd0, 3'b000, 32'h7F800000, 3'b011, 4'd10}, // R10 via carry
    {1'b0, 10'h3FF,  32'h80000000, 2'd0, 3'b000, 32'h00400000, 3'b000, 4'd11}, // R11 exact tiny
    {1'b0, 10'h3FF,  32'h80000001, 2'd0, 3'b000, 32'h00400000, 3'b101, 4'd11}, // R11 inexact tiny
    {1'b0, 10'h3FF,  32'hFFFFFFFF, 2'd0, 3'b000, 32'h00800000, 3'b001, 4'd11}, // R11 rounds to normal
    {1'b0, 10'h3D8,  32'h80000000, 2'd0, 3'b000, 32'h00000000, 3'b101, 4'd11}, // R11 long shift
    {1'b0, 10'h3D8,  32'h80000000, 2'd1, 3'b000, 32'h00000001, 3'b101, 4'd11}, // R11 long shift up
    {1'b1, 10'd50,   32'h00000000, 2'd0, 3'b000, 32'h80000000, 3'b000, 4'd4},  // R4 signed zero
    {1'b0, 10'd255,  32'h00000000, 2'd0, 3'b000, 32'h7F800000, 3'b000, 4'd3},  // R3 infinity
    {1'b0, 10'd255,  32'h20000000, 2'd0, 3'b001, 32'h7FC00000, 3'b001, 4'd3},  // R3 NaN with flag
    {1'b0, 10'd127,  32'h40000000, 2'd0, 3'b010, 32'h3F800000, 3'b010, 4'd12}  // R12 flag merge
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sign = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  in_mode = '0;
  logic [2:0]  in_exc = '0;
  logic        out_valid, out_ixc, out_ofc, out_ufc;
  logic [31:0] out_word;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] held;

  always #5 clk = ~clk;

  nrp_unit i_nrp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign), .in_exp(in_exp),
    .in_sig(in_sig), .in_mode(in_mode), .in_exc(in_exc), .out_valid(out_valid),
    .out_word(out_word), .out_ixc(out_ixc), .out_ofc(out_ofc), .out_ufc(out_ufc)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, out_word, out_ufc, out_ofc, out_ixc}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {out_valid, out_word, out_ufc, out_ofc, out_ixc}, '0);

    for (int k = 0; k < NV; k++) begin
      {in_sign, in_exp, in_sig, in_mode, in_exc} = VEC[k][86:39];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec %0d word", VEC[k][3:0], k), {4'h0, out_word}, {4'h0, VEC[k][38:7]});
      check($sformatf("R%0d vec %0d flags", VEC[k][3:0], k),
            {32'h0, out_valid, out_ufc, out_ofc, out_ixc}, {32'h0, 1'b1, VEC[k][6:4]});
    end

    // R2: idle cycle keeps the last result and lowers valid
    held = out_word;
    in_valid = 1'b0;
    in_sig = 32'h12345678; in_exp = 10'd100;
    @(negedge clk);
    check("R2 idle hold", {3'b0, out_valid, out_word}, {4'h0, held});

    // R1: reset in mid-run clears the registers
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {out_valid, out_word, out_ufc, out_ofc, out_ixc}, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule